// File: doc/BRIEF.md
# Masked Pending-Bit Interrupt Aggregator

This block gathers eight interrupt sources into one pending vector and drives a single upstream request. Sources add pending bits through a set vector and remove them through a clear vector. Software writes a primary enable mask through a byte write port. A mask bit of 1 lets the matching pending bit reach the request, and a bit of 0 hides it. A second, auxiliary mask shares the same write port. It is kept and made visible, but it never takes part in the request.

The block keeps a flag that records whether it is currently signalling upstream. It changes that flag only on transitions. A set, or a primary-mask write, that leaves an enabled bit pending raises the request. Only a clear operation that leaves no enabled bit pending lowers it. A mask write that hides every pending bit therefore leaves an asserted request standing until a clear arrives. The request appears as one bit at a fixed position of a wide system interrupt word. The pending vector and both masks are brought out so that the system can observe them.

Top module: `irq_gather_top`

## Requirements
- R1: After reset the pending vector is 0x00, both masks read 0xFF and every bit of the interrupt word is 0.
- R2: A nonzero set vector is ORed into the pending vector, which shows the new bits one cycle later.
- R3: A nonzero clear vector removes its bits from the pending vector one cycle later. When a set and a clear name the same bit in the same cycle, the clear wins and the bit ends up 0.
- R4: A write with `mask_sel_i`=0 stores `mask_wdata_i` as the primary mask. A write with `mask_sel_i`=1 stores it as the auxiliary mask. Each is visible one cycle later.
- R5: While the request is low, a set or a primary-mask write raises the request one cycle later if the new pending vector ANDed with the new primary mask is nonzero. No other operation raises it.
- R6: A clear lowers the request one cycle later when the pending vector after the clear, ANDed with the primary mask, is zero. A clear that leaves an enabled bit pending keeps the request high.
- R7: A primary-mask write that hides every pending bit does not lower an asserted request.
- R8: Auxiliary-mask writes change neither the pending vector nor the request.
- R9: The request occupies bit 55 of the 64-bit interrupt word, and all other bits of the word stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_set_i | input | 8 | Per-source set vector, sampled every cycle |
| src_clr_i | input | 8 | Per-source clear vector, applied after the set |
| mask_we_i | input | 1 | Mask write strobe |
| mask_sel_i | input | 1 | Mask select: 0 primary, 1 auxiliary |
| mask_wdata_i | input | 8 | Mask write data |
| pend_o | output | 8 | Current pending vector |
| mask_pri_o | output | 8 | Current primary mask |
| mask_aux_o | output | 8 | Current auxiliary mask |
| irq_word_o | output | 64 | System interrupt word; bit 55 carries the request |

## Verification
The signalling flag is the only state that is not directly visible. If it goes wrong, bit 55 of the interrupt word disagrees with the reference model on the very next cycle after the event that should have moved it. That happens most visibly when a mask write hides all pending bits, or when a clear leaves an enabled bit still pending. A wrong pending bit or mask bit shows on `pend_o` or on a mask output one cycle after the offending set, clear or write. It then spreads to the request at the next raise or lower decision. Because the reference model runs alongside the design and is compared every cycle, a divergence is reported in the cycle it first appears.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

    localparam int unsigned MASK_COUNT = 2;

    typedef enum logic {
        MSEL_PRI = 1'b0,
        MSEL_AUX = 1'b1
    } mask_sel_e;

endpackage

// File: rtl/irq_mask_bank.sv
module irq_mask_bank
    import irq_gather_pkg::*;
#(
    parameter int unsigned SRC_W   = 8,
    parameter logic [SRC_W-1:0] RST_VAL = '1
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             we_i,
    input  logic             sel_i,
    input  logic [SRC_W-1:0] wdata_i,
    output logic [SRC_W-1:0] pri_q_o,
    output logic [SRC_W-1:0] pri_d_o,
    output logic [SRC_W-1:0] aux_q_o
);

    typedef struct packed {
        logic [MASK_COUNT-1:0][SRC_W-1:0] m;
    } bank_t;

    bank_t bank_d, bank_q;

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < MASK_COUNT; i++) begin
            if (we_i && (int'(sel_i) == i)) begin
                bank_d.m[i] = wdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < MASK_COUNT; i++) begin
                bank_q.m[i] <= RST_VAL;
            end
        end else begin
            bank_q <= bank_d;
        end
    end

    assign pri_q_o = bank_q.m[MSEL_PRI];
    assign pri_d_o = bank_d.m[MSEL_PRI];
    assign aux_q_o = bank_q.m[MSEL_AUX];

    // R4: a write lands in the selected mask only
    a_r4_pri_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == MSEL_PRI) |=> (pri_q_o == $past(wdata_i)));
    a_r4_aux_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (we_i && sel_i == MSEL_AUX) |=> (aux_q_o == $past(wdata_i)
                                         && $stable(pri_q_o)));

endmodule

// File: rtl/irq_pending_reg.sv
module irq_pending_reg #(
    parameter int unsigned SRC_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SRC_W-1:0] set_i,
    input  logic [SRC_W-1:0] clr_i,
    output logic [SRC_W-1:0] pend_q_o,
    output logic [SRC_W-1:0] pend_set_o,
    output logic [SRC_W-1:0] pend_d_o
);

    typedef struct packed {
        logic [SRC_W-1:0] pend;
    } pend_t;

    pend_t st_d, st_q;
    logic [SRC_W-1:0] after_set;

    always_comb begin
        st_d      = st_q;
        after_set = st_q.pend | set_i;
        st_d.pend = after_set & ~clr_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_q_o   = st_q.pend;
    assign pend_set_o = after_set;
    assign pend_d_o   = st_d.pend;

    // R2: set bits not cleared in the same cycle are present next cycle
    a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|set_i) |=> ((pend_q_o & $past(set_i & ~clr_i)) == $past(set_i & ~clr_i)));
    // R3: cleared bits are gone next cycle, even if set at the same time
    a_r3_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (|clr_i) |=> ((pend_q_o & $past(clr_i)) == '0));
    // R3: untouched bits hold
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (set_i == '0 && clr_i == '0) |=> $stable(pend_q_o));

endmodule

// File: rtl/irq_post_track.sv
module irq_post_track (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic raise_evt_i,
    input  logic raise_vis_i,
    input  logic lower_evt_i,
    input  logic lower_empty_i,
    output logic active_o
);

    typedef struct packed {
        logic active;
    } post_t;

    post_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (raise_evt_i && raise_vis_i && !st_q.active) begin
            st_d.active = 1'b1;
        end
        if (lower_evt_i && lower_empty_i) begin
            st_d.active = 1'b0;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign active_o = st_q.active;

    // R5: an exposing set or mask write raises the request
    a_r5_raise: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (raise_evt_i && raise_vis_i && !lower_evt_i) |=> active_o);
    // R5: nothing but a set or primary write raises it
    a_r5_no_spurious: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!active_o && !raise_evt_i) |=> !active_o);
    // R6: a clear that empties the enabled set lowers it
    a_r6_lower: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (lower_evt_i && lower_empty_i) |=> !active_o);
    // R7: without a clear the request never falls
    a_r7_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (active_o && !lower_evt_i) |=> active_o);

endmodule

// File: rtl/irq_gather_top.sv
module irq_gather_top
    import irq_gather_pkg::*;
#(
    parameter int unsigned SRC_W   = 8,
    parameter int unsigned WORD_W  = 64,
    parameter int unsigned REQ_BIT = 55
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [SRC_W-1:0]  src_set_i,
    input  logic [SRC_W-1:0]  src_clr_i,
    input  logic              mask_we_i,
    input  logic              mask_sel_i,
    input  logic [SRC_W-1:0]  mask_wdata_i,
    output logic [SRC_W-1:0]  pend_o,
    output logic [SRC_W-1:0]  mask_pri_o,
    output logic [SRC_W-1:0]  mask_aux_o,
    output logic [WORD_W-1:0] irq_word_o
);

    localparam logic [WORD_W-1:0] REQ_ONE = WORD_W'(1) << REQ_BIT;

    logic [SRC_W-1:0] pri_d;
    logic [SRC_W-1:0] pend_set, pend_d;
    logic             pri_write, raise_evt, raise_vis, lower_evt, lower_empty;
    logic             active;

    irq_mask_bank #(.SRC_W(SRC_W), .RST_VAL('1)) u_masks (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .we_i    (mask_we_i),
        .sel_i   (mask_sel_i),
        .wdata_i (mask_wdata_i),
        .pri_q_o (mask_pri_o),
        .pri_d_o (pri_d),
        .aux_q_o (mask_aux_o)
    );

    irq_pending_reg #(.SRC_W(SRC_W)) u_pend (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .set_i      (src_set_i),
        .clr_i      (src_clr_i),
        .pend_q_o   (pend_o),
        .pend_set_o (pend_set),
        .pend_d_o   (pend_d)
    );

    assign pri_write   = mask_we_i && (mask_sel_i == MSEL_PRI);
    assign raise_evt   = (|src_set_i) || pri_write;
    assign raise_vis   = |(pend_set & pri_d);
    assign lower_evt   = |src_clr_i;
    assign lower_empty = ~|(pend_d & pri_d);

    irq_post_track u_post (
        .clk_i         (clk_i),
        .rst_ni        (rst_ni),
        .raise_evt_i   (raise_evt),
        .raise_vis_i   (raise_vis),
        .lower_evt_i   (lower_evt),
        .lower_empty_i (lower_empty),
        .active_o      (active)
    );

    assign irq_word_o = active ? REQ_ONE : '0;

    // R8: an auxiliary write alone leaves pending and request untouched
    a_r8_aux_inert: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mask_we_i && mask_sel_i == MSEL_AUX && src_set_i == '0 && src_clr_i == '0)
        |=> ($stable(irq_word_o) && $stable(pend_o)));
    // R9: never more than the single request bit in the word
    a_r9_single_bit: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(irq_word_o));
    // R7: hiding every pending bit through the mask keeps the word asserted
    a_r7_mask_hide: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_word_o[REQ_BIT] && pri_write && src_clr_i == '0) |=> irq_word_o[REQ_BIT]);

endmodule

// File: tb/test_irq_gather_top.sv
module test_irq_gather_top;

    localparam int CLK_HALF  = 10;
    localparam int LIMIT_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  set_v = '0, clr_v = '0, wdata = '0;
    logic        we = 1'b0, sel = 1'b0;
    logic [7:0]  pend, mpri, maux;
    logic [63:0] word;

    int n_checks = 0, n_fail = 0, cycles = 0;
    bit started = 0;
    string tag = "R1";

    int m_pend, m_pri, m_aux;
    bit m_sig;

    always #CLK_HALF clk = ~clk;

    irq_gather_top i_irq_gather_top (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .src_set_i    (set_v),
        .src_clr_i    (clr_v),
        .mask_we_i    (we),
        .mask_sel_i   (sel),
        .mask_wdata_i (wdata),
        .pend_o       (pend),
        .mask_pri_o   (mpri),
        .mask_aux_o   (maux),
        .irq_word_o   (word)
    );

    // Behavioural reference: mask write, then set, then clear, in that order
    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = 0; m_pri = 255; m_aux = 255; m_sig = 0;
        end else begin
            int after_set;
            bit exposing;
            if (we && sel == 1'b0) m_pri = int'(wdata);
            if (we && sel == 1'b1) m_aux = int'(wdata);
            after_set = m_pend | int'(set_v);
            exposing  = (set_v != 0) || (we && sel == 1'b0);
            if (exposing && ((after_set & m_pri) != 0)) m_sig = 1;
            m_pend = after_set & ~int'(clr_v) & 255;
            if (clr_v != 0 && ((m_pend & m_pri) == 0)) m_sig = 0;
        end
    end

    task automatic check(string t, string what, longint act, longint exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", t, what, act, exp);
        end
    endtask

    // Every-cycle comparison against the model
    always @(negedge clk) begin
        if (started) begin
            logic [63:0] exp_word;
            exp_word = m_sig ? (64'd1 << 55) : 64'd0;
            check(tag, "pend", longint'(pend), longint'(m_pend));
            check(tag, "mask_pri", longint'(mpri), longint'(m_pri));
            check(tag, "mask_aux", longint'(maux), longint'(m_aux));
            check({tag, "/R9"}, "irq_word", longint'(word), longint'(exp_word));
        end
    end

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > LIMIT_CYC) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cycles, LIMIT_CYC);
            finish_run();
        end
    end

    // One cycle of stimulus; results are visible at the following negedge
    task automatic step(input logic [7:0] s, input logic [7:0] c,
                        input logic w, input logic sl, input logic [7:0] d);
        set_v = s; clr_v = c; we = w; sel = sl; wdata = d;
        @(negedge clk);
        set_v = '0; clr_v = '0; we = 1'b0; sel = 1'b0; wdata = '0;
    endtask

    task automatic expect_req(string t, bit exp);
        check(t, "request bit", longint'(word[55]), longint'(exp));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        started = 1;
        // R1: reset values
        check("R1", "pend", longint'(pend), 0);
        check("R1", "mask_pri", longint'(mpri), 255);
        check("R1", "mask_aux", longint'(maux), 255);
        check("R1", "word", longint'(word), 0);

        tag = "R2";
        step(8'h05, 8'h00, 0, 0, 8'h00);
        check("R2", "pend after set", longint'(pend), 5);
        expect_req("R5", 1);

        tag = "R6";
        step(8'h00, 8'h01, 0, 0, 8'h00);
        expect_req("R6 partial clear keeps", 1);
        step(8'h00, 8'h04, 0, 0, 8'h00);
        expect_req("R6 full clear lowers", 0);

        tag = "R4";
        step(8'h00, 8'h00, 1, 0, 8'h00);
        check("R4", "mask_pri", longint'(mpri), 0);
        tag = "R5";
        step(8'h10, 8'h00, 0, 0, 8'h00);
        expect_req("R5 hidden set", 0);
        step(8'h00, 8'h00, 1, 0, 8'h10);
        expect_req("R5 mask exposes", 1);

        tag = "R7";
        step(8'h00, 8'h00, 1, 0, 8'h00);
        expect_req("R7 mask hide holds", 1);
        step(8'h00, 8'h10, 0, 0, 8'h00);
        expect_req("R6 clear after hide", 0);

        tag = "R8";
        step(8'h00, 8'h00, 1, 0, 8'h0F);
        step(8'h02, 8'h00, 0, 0, 8'h00);
        expect_req("R8 setup", 1);
        step(8'h00, 8'h00, 1, 1, 8'h00);
        check("R8", "mask_aux", longint'(maux), 0);
        expect_req("R8 aux write inert", 1);
        check("R8", "pend", longint'(pend), 2);

        tag = "R3";
        step(8'h08, 8'h0A, 0, 0, 8'h00);
        check("R3", "pend set+clear", longint'(pend), 0);
        expect_req("R3 clear wins", 0);

        tag = "R5";
        step(8'h00, 8'h00, 1, 0, 8'hF0);
        step(8'h80, 8'h00, 0, 0, 8'h00);
        step(8'h00, 8'h00, 1, 0, 8'h00);
        step(8'h01, 8'h00, 0, 0, 8'h00);
        expect_req("R5 set while already high", 1);

        tag = "R2/R3/R5/R6/R7/R8";
        for (int i = 0; i < 600; i++) begin
            logic [7:0] s, c, d;
            logic w, sl;
            s  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            c  = 8'($urandom) & 8'($urandom) & 8'($urandom);
            d  = 8'($urandom);
            w  = ($urandom % 5) == 0;
            sl = 1'($urandom);
            step(s, c, w, sl, d);
        end

        finish_run();
    end

endmodule